// File: doc/BRIEF.md
# Primary Opcode Class and Cycle Decoder

This block is a purely combinational decoder for the first byte of an 8-bit processor instruction. It cuts the byte into a two-bit group field (bits 7:6), a three-bit upper field (bits 5:3) and a three-bit lower field (bits 2:0). From these it produces an instruction class code, the register and register-pair indices, the condition selector, an ALU operation select, and the number of machine clock cycles the instruction costs.

The cycle count is not fixed for every opcode. Conditional branches, calls and returns cost more when their condition holds, so the decoder takes the current zero and carry flags, evaluates the condition itself and reports whether the transfer is taken. Register loads and register ALU operations cost more when a field selects the memory operand (index 6). The decoder also marks the bit-manipulation prefix byte, the halt encoding, the interrupt master-enable side effects and the eleven unused slots of the top group. It has no clock and no state. The fetch sequencer drives the opcode and flags and reads the results in the same cycle; there is no data stream and no back-pressure.

Top module: `opcode_timing_decoder`

## Requirements
- R1: `reg_dst` equals opcode bits 5:3, `reg_src` equals bits 2:0, `reg_pair` equals bits 5:4 and `cond_code` equals bits 4:3, for every opcode.
- R2: `cond_met` is 1 when the condition holds: code 0 needs zero flag clear, 1 needs zero flag set, 2 needs carry clear, 3 needs carry set. `taken` is `cond_met` for the conditional opcodes 0x20, 0x28, 0x30, 0x38, 0xC0, 0xC8, 0xD0, 0xD8, 0xC2, 0xCA, 0xD2, 0xDA, 0xC4, 0xCC, 0xD4 and 0xDC, and 0 for all others.
- R3: The conditional relative jump costs 8 cycles, or 12 when taken. The conditional absolute jump costs 12, or 16. The conditional call costs 12, or 24. The conditional return costs 8, or 20.
- R4: These cycle counts hold: 0x18 is 12, 0xC3 is 16, 0xCD is 24, 0xC9 and 0xD9 are 16, 0xE9 is 4, and any opcode of the form 11yyy111 is 16. `rst_addr` equals the opcode ANDed with 0x38 for those restart opcodes, and is 0 otherwise.
- R5: In group 01, the cost is 4 cycles, or 8 when either field is 6. Opcode 0x76 costs 4 cycles. `halt` is high for 0x76 only.
- R6: `alu_en` is high for all of group 10 and for the opcodes of the form 11yyy110. When `alu_en` is high, `alu_op` equals bits 5:3 (0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 XOR, 6 OR, 7 compare). Otherwise `alu_op` is 0. In group 10, the cost is 4 cycles, or 8 when bits 2:0 are 6. The immediate forms cost 8.
- R7: The other top-group opcodes have these costs. 0xE0 and 0xF0 are 12. 0xE2 and 0xF2 are 8. 0xEA and 0xFA are 16. 0xE8 is 16, 0xF8 is 12 and 0xF9 is 8. The pop opcodes (11yy0001, yy below 3) are 12 and the push opcodes (11yy0101) are 16. 0xCB, 0xF3 and 0xFB are 4.
- R8: Group 00 has these costs. 0x00 and 0x10 are 4 cycles and 0x08 is 20. The 16-bit immediate loads (00pp0001) are 12. The 16-bit adds (00pp1001) are 8. Indirect accumulator moves (lower field 2) are 8. The 16-bit increments and decrements (lower field 3) are 8. The 8-bit increments and decrements (lower field 4 or 5) are 4. The 8-bit immediate loads (lower field 6) are 8. The accumulator operations (lower field 7) are 4.
- R9: `illegal` is high for 0xD3, 0xDB, 0xDD, 0xE3, 0xE4, 0xEB, 0xEC, 0xED, 0xF4, 0xFC and 0xFD only. Each of these costs 4 cycles and holds `taken`, `halt`, `cb_prefix`, `alu_en` and both enable outputs low.
- R10: `cb_prefix` is high for 0xCB only.
- R11: `ime_set` is high for 0xFB and 0xD9. `ime_clr` is high for 0xF3 only. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 8 | Primary instruction byte |
| flag_z | input | 1 | Current zero flag |
| flag_c | input | 1 | Current carry flag |
| iclass | output | 5 | Instruction class code (package enum) |
| reg_dst | output | 3 | Upper register field |
| reg_src | output | 3 | Lower register field |
| reg_pair | output | 2 | Register-pair index |
| cond_code | output | 2 | Condition selector field |
| cond_met | output | 1 | Condition holds under current flags |
| taken | output | 1 | Conditional transfer will be taken |
| cycles | output | 5 | Machine clock cycles for this instruction |
| illegal | output | 1 | Opcode falls in an unused slot |
| cb_prefix | output | 1 | Byte selects the bit-manipulation page |
| ime_set | output | 1 | Instruction sets interrupt master enable |
| ime_clr | output | 1 | Instruction clears interrupt master enable |
| halt | output | 1 | Halt encoding |
| alu_en | output | 1 | Instruction uses the 8-bit ALU on the accumulator |
| alu_op | output | 3 | ALU operation select |
| rst_addr | output | 8 | Restart target address |

## Verification
The assertions assume that only known values reach `opcode`, `flag_z` and `flag_c`. They also assume that the outputs are sampled after the inputs have settled, because every property is evaluated combinationally over the current vector. The stimulus changes the inputs only on the falling clock edge and holds them steady until the next one. It applies each of the 256 opcodes under all four zero/carry combinations, so every input the decoder can see is a known, settled value when the properties are evaluated.

// File: rtl/opdec_pkg.sv
package opdec_pkg;

  localparam int OD_OPC_W = 8;
  localparam int OD_FLD_W = 3;
  localparam int OD_CC_W  = 2;
  localparam int OD_CYC_W = 5;

  typedef enum logic [4:0] {
    CL_NOP, CL_STOP, CL_HALT, CL_LD_REG, CL_LD_IMM8, CL_LD_IMM16,
    CL_LD_IND_A, CL_ST_SP, CL_ALU_REG, CL_ALU_IMM, CL_INCDEC8,
    CL_INCDEC16, CL_ADD_HL, CL_ACC_MISC, CL_JR, CL_JP, CL_JP_HL,
    CL_CALL, CL_RET, CL_RETI, CL_RST, CL_PUSH, CL_POP, CL_HIGH_PAGE,
    CL_LD_ABS_A, CL_SP_ARITH, CL_PREFIX, CL_IME_CTL, CL_ILLEGAL
  } iclass_e;

  typedef struct packed {
    iclass_e               cls;
    logic [OD_CYC_W-1:0]   cyc_nt;
    logic [OD_CYC_W-1:0]   cyc_tk;
    logic                  is_cond;
    logic                  illegal;
    logic                  prefix;
    logic                  ime_set;
    logic                  ime_clr;
    logic                  halt;
    logic                  alu_en;
    logic                  rst;
  } dec_t;

  // Unconditional entry: both cycle slots carry the same cost.
  function automatic dec_t od_mk(iclass_e c, logic [OD_CYC_W-1:0] n);
    dec_t r;
    r         = '0;
    r.cls     = c;
    r.cyc_nt  = n;
    r.cyc_tk  = n;
    return r;
  endfunction

  // Conditional entry: separate not-taken and taken costs.
  function automatic dec_t od_cond(iclass_e c, logic [OD_CYC_W-1:0] n,
                                   logic [OD_CYC_W-1:0] t);
    dec_t r;
    r         = od_mk(c, n);
    r.cyc_tk  = t;
    r.is_cond = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/opdec_cond.sv
module opdec_cond
  import opdec_pkg::*;
#(
  parameter int CC_W = OD_CC_W
) (
  input  logic [CC_W-1:0] cc,
  input  logic            fz,
  input  logic            fc,
  output logic            met
);
  // cc[1] picks the flag, cc[0] picks the polarity
  logic sel_flag;
  assign sel_flag = cc[1] ? fc : fz;
  assign met      = cc[0] ? sel_flag : ~sel_flag;
endmodule

// File: rtl/opdec_grp_lo.sv
module opdec_grp_lo
  import opdec_pkg::*;
#(
  parameter int              FLD_W   = OD_FLD_W,
  parameter logic [FLD_W-1:0] MEM_IDX = 3'd6
) (
  input  logic [1:0]       grp,
  input  logic [FLD_W-1:0] y,
  input  logic [FLD_W-1:0] z,
  output dec_t             d
);
  logic y_mem, z_mem;
  assign y_mem = (y == MEM_IDX);
  assign z_mem = (z == MEM_IDX);

  always_comb begin
    d = od_mk(CL_NOP, 5'd4);
    case (grp)
      2'b00: begin
        case (z)
          3'd0: begin
            case (y)
              3'd0:    d = od_mk(CL_NOP, 5'd4);
              3'd1:    d = od_mk(CL_ST_SP, 5'd20);
              3'd2:    d = od_mk(CL_STOP, 5'd4);
              3'd3:    d = od_mk(CL_JR, 5'd12);
              default: d = od_cond(CL_JR, 5'd8, 5'd12);
            endcase
          end
          3'd1:    d = y[0] ? od_mk(CL_ADD_HL, 5'd8) : od_mk(CL_LD_IMM16, 5'd12);
          3'd2:    d = od_mk(CL_LD_IND_A, 5'd8);
          3'd3:    d = od_mk(CL_INCDEC16, 5'd8);
          3'd4,
          3'd5:    d = od_mk(CL_INCDEC8, 5'd4);
          3'd6:    d = od_mk(CL_LD_IMM8, 5'd8);
          default: d = od_mk(CL_ACC_MISC, 5'd4);
        endcase
      end
      2'b01: begin
        if (y_mem && z_mem) begin
          d      = od_mk(CL_HALT, 5'd4);
          d.halt = 1'b1;
        end else begin
          d = od_mk(CL_LD_REG, (y_mem || z_mem) ? 5'd8 : 5'd4);
        end
      end
      default: begin
        d        = od_mk(CL_ALU_REG, z_mem ? 5'd8 : 5'd4);
        d.alu_en = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/opdec_grp_hi.sv
module opdec_grp_hi
  import opdec_pkg::*;
#(
  parameter int FLD_W = OD_FLD_W
) (
  input  logic [FLD_W-1:0] y,
  input  logic [FLD_W-1:0] z,
  output dec_t             d
);
  dec_t bad;
  assign bad = '{cls: CL_ILLEGAL, cyc_nt: 5'd4, cyc_tk: 5'd4, illegal: 1'b1,
                 default: '0};

  always_comb begin
    d = bad;
    case (z)
      3'd0: begin
        case (y)
          3'd4, 3'd6: d = od_mk(CL_HIGH_PAGE, 5'd12);
          3'd5:       d = od_mk(CL_SP_ARITH, 5'd16);
          3'd7:       d = od_mk(CL_SP_ARITH, 5'd12);
          default:    d = od_cond(CL_RET, 5'd8, 5'd20);
        endcase
      end
      3'd1: begin
        case (y)
          3'd1: d = od_mk(CL_RET, 5'd16);
          3'd3: begin
            d         = od_mk(CL_RETI, 5'd16);
            d.ime_set = 1'b1;
          end
          3'd5:    d = od_mk(CL_JP_HL, 5'd4);
          3'd7:    d = od_mk(CL_SP_ARITH, 5'd8);
          default: d = od_mk(CL_POP, 5'd12);
        endcase
      end
      3'd2: begin
        case (y)
          3'd4, 3'd6: d = od_mk(CL_HIGH_PAGE, 5'd8);
          3'd5, 3'd7: d = od_mk(CL_LD_ABS_A, 5'd16);
          default:    d = od_cond(CL_JP, 5'd12, 5'd16);
        endcase
      end
      3'd3: begin
        case (y)
          3'd0: d = od_mk(CL_JP, 5'd16);
          3'd1: begin
            d        = od_mk(CL_PREFIX, 5'd4);
            d.prefix = 1'b1;
          end
          3'd6: begin
            d         = od_mk(CL_IME_CTL, 5'd4);
            d.ime_clr = 1'b1;
          end
          3'd7: begin
            d         = od_mk(CL_IME_CTL, 5'd4);
            d.ime_set = 1'b1;
          end
          default: d = bad;
        endcase
      end
      3'd4: d = y[2] ? bad : od_cond(CL_CALL, 5'd12, 5'd24);
      3'd5: begin
        if (!y[0])        d = od_mk(CL_PUSH, 5'd16);
        else if (y == 3'd1) d = od_mk(CL_CALL, 5'd24);
        else              d = bad;
      end
      3'd6: begin
        d        = od_mk(CL_ALU_IMM, 5'd8);
        d.alu_en = 1'b1;
      end
      default: begin
        d     = od_mk(CL_RST, 5'd16);
        d.rst = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/opcode_timing_decoder.sv
module opcode_timing_decoder
  import opdec_pkg::*;
#(
  parameter int               OPC_W   = OD_OPC_W,
  parameter int               FLD_W   = OD_FLD_W,
  parameter int               CC_W    = OD_CC_W,
  parameter int               CYC_W   = OD_CYC_W,
  parameter logic [FLD_W-1:0] MEM_IDX = 3'd6
) (
  input  logic [OPC_W-1:0] opcode,
  input  logic             flag_z,
  input  logic             flag_c,
  output logic [4:0]       iclass,
  output logic [FLD_W-1:0] reg_dst,
  output logic [FLD_W-1:0] reg_src,
  output logic [1:0]       reg_pair,
  output logic [CC_W-1:0]  cond_code,
  output logic             cond_met,
  output logic             taken,
  output logic [CYC_W-1:0] cycles,
  output logic             illegal,
  output logic             cb_prefix,
  output logic             ime_set,
  output logic             ime_clr,
  output logic             halt,
  output logic             alu_en,
  output logic [FLD_W-1:0] alu_op,
  output logic [OPC_W-1:0] rst_addr
);
  localparam int GRP_LSB = 2 * FLD_W;
  localparam int PAD_W   = OPC_W - 2 * FLD_W;

  logic [1:0]       grp;
  logic [FLD_W-1:0] fy, fz;
  dec_t             d_lo, d_hi, d_sel;

  assign grp = opcode[GRP_LSB +: 2];
  assign fy  = opcode[FLD_W +: FLD_W];
  assign fz  = opcode[0 +: FLD_W];

  opdec_cond #(.CC_W(CC_W)) u_cond (
    .cc  (fy[CC_W-1:0]),
    .fz  (flag_z),
    .fc  (flag_c),
    .met (cond_met)
  );

  opdec_grp_lo #(.FLD_W(FLD_W), .MEM_IDX(MEM_IDX)) u_lo (
    .grp (grp),
    .y   (fy),
    .z   (fz),
    .d   (d_lo)
  );

  opdec_grp_hi #(.FLD_W(FLD_W)) u_hi (
    .y (fy),
    .z (fz),
    .d (d_hi)
  );

  assign d_sel = (&grp) ? d_hi : d_lo;

  assign iclass    = d_sel.cls;
  assign reg_dst   = fy;
  assign reg_src   = fz;
  assign reg_pair  = fy[FLD_W-1 -: 2];
  assign cond_code = fy[CC_W-1:0];
  assign taken     = d_sel.is_cond & cond_met;
  assign cycles    = taken ? d_sel.cyc_tk : d_sel.cyc_nt;
  assign illegal   = d_sel.illegal;
  assign cb_prefix = d_sel.prefix;
  assign ime_set   = d_sel.ime_set;
  assign ime_clr   = d_sel.ime_clr;
  assign halt      = d_sel.halt;
  assign alu_en    = d_sel.alu_en;
  assign alu_op    = d_sel.alu_en ? fy : '0;
  assign rst_addr  = d_sel.rst ? {{PAD_W{1'b0}}, fy, {FLD_W{1'b0}}} : '0;
endmodule

// File: rtl/opdec_checker.sv
module opdec_checker (
  input logic [7:0] opcode,
  input logic       cond_met,
  input logic       taken,
  input logic [4:0] cycles,
  input logic       illegal,
  input logic       cb_prefix,
  input logic       ime_set,
  input logic       ime_clr,
  input logic       halt,
  input logic       alu_en
);
  always_comb begin
    assert_taken_needs_cond_R2: assert (!taken || cond_met)
      else $error("taken without condition");
    assert_taken_cost_R3: assert (!taken || cycles >= 5'd12)
      else $error("taken transfer too cheap");
    assert_cycle_grain_R8: assert (cycles != 5'd0 && cycles[1:0] == 2'b00)
      else $error("cycle count not a multiple of four");
    assert_halt_group_R5: assert (!halt || (opcode[7:6] == 2'b01 && cycles == 5'd4))
      else $error("halt outside load group");
    assert_illegal_quiet_R9: assert (!illegal ||
        (opcode[7:6] == 2'b11 && !taken && !halt && !cb_prefix && !alu_en &&
         !ime_set && !ime_clr && cycles == 5'd4))
      else $error("illegal slot side effect");
    assert_prefix_only_R10: assert (!cb_prefix || (opcode == 8'hCB && cycles == 5'd4))
      else $error("prefix on wrong byte");
    assert_ime_exclusive_R11: assert (!(ime_set && ime_clr))
      else $error("enable set and clear together");
  end
endmodule

bind opcode_timing_decoder opdec_checker u_chk (
  .opcode    (opcode),
  .cond_met  (cond_met),
  .taken     (taken),
  .cycles    (cycles),
  .illegal   (illegal),
  .cb_prefix (cb_prefix),
  .ime_set   (ime_set),
  .ime_clr   (ime_clr),
  .halt      (halt),
  .alu_en    (alu_en)
);

// File: tb/sim_opcode_timing_decoder.sv
module sim_opcode_timing_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] op = 8'h00;
  logic       fz = 1'b0, fc = 1'b0;

  logic [4:0] iclass, cycles;
  logic [2:0] reg_dst, reg_src, alu_op;
  logic [1:0] reg_pair, cond_code;
  logic       cond_met, taken, illegal, cb_prefix, ime_set, ime_clr, halt, alu_en;
  logic [7:0] rst_addr;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  opcode_timing_decoder u0 (
    .opcode(op), .flag_z(fz), .flag_c(fc), .iclass(iclass),
    .reg_dst(reg_dst), .reg_src(reg_src), .reg_pair(reg_pair),
    .cond_code(cond_code), .cond_met(cond_met), .taken(taken),
    .cycles(cycles), .illegal(illegal), .cb_prefix(cb_prefix),
    .ime_set(ime_set), .ime_clr(ime_clr), .halt(halt),
    .alu_en(alu_en), .alu_op(alu_op), .rst_addr(rst_addr)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s op=%02h z=%0b c=%0b actual=%0d expected=%0d",
               tag, what, op, fz, fc, act, exp);
    end
  endtask

  function automatic bit is_bad(int o);
    return o == 'hD3 || o == 'hDB || o == 'hDD || o == 'hE3 || o == 'hE4 ||
           o == 'hEB || o == 'hEC || o == 'hED || o == 'hF4 || o == 'hFC ||
           o == 'hFD;
  endfunction

  function automatic bit is_cnd(int o);
    int g = o / 64, y = (o / 8) % 8, x = o % 8;
    return (g == 0 && x == 0 && y >= 4) ||
           (g == 3 && y < 4 && (x == 0 || x == 2 || x == 4));
  endfunction

  function automatic bit met_of(int o, bit z, bit c);
    case ((o / 8) % 4)
      0: return !z;
      1: return z;
      2: return !c;
      default: return c;
    endcase
  endfunction

  function automatic int exp_cyc(int o, bit z, bit c);
    int g = o / 64, y = (o / 8) % 8, x = o % 8;
    bit m = met_of(o, z, c);
    if (g == 1) return (o == 'h76) ? 4 : ((y == 6 || x == 6) ? 8 : 4);
    if (g == 2) return (x == 6) ? 8 : 4;
    if (g == 0) begin
      case (x)
        0: begin
          if (o == 'h00 || o == 'h10) return 4;
          if (o == 'h08) return 20;
          if (o == 'h18) return 12;
          return m ? 12 : 8;
        end
        1: return (y % 2 == 1) ? 8 : 12;
        2, 3: return 8;
        4, 5: return 4;
        6: return 8;
        default: return 4;
      endcase
    end
    if (is_bad(o)) return 4;
    case (o)
      'hCB, 'hF3, 'hFB, 'hE9: return 4;
      'hC3, 'hC9, 'hD9, 'hEA, 'hFA, 'hE8: return 16;
      'hCD: return 24;
      'hF9, 'hE2, 'hF2: return 8;
      'hE0, 'hF0, 'hF8: return 12;
      default: ;
    endcase
    case (x)
      6: return 8;
      7: return 16;
      1: return 12;
      5: return 16;
      0: return m ? 20 : 8;
      2: return m ? 16 : 12;
      default: return m ? 24 : 12;
    endcase
  endfunction

  function automatic string cyc_tag(int o);
    int g = o / 64, x = o % 8;
    if (is_cnd(o)) return "R3";
    if (g == 0) return (o == 'h18) ? "R4" : "R8";
    if (g == 1) return "R5";
    if (g == 2 || x == 6) return "R6";
    if (is_bad(o)) return "R9";
    if (x == 7 || o == 'hC3 || o == 'hCD || o == 'hC9 || o == 'hD9 || o == 'hE9) return "R4";
    return "R7";
  endfunction

  task automatic apply(input int o, input bit z, input bit c);
    int g = o / 64, y = (o / 8) % 8, x = o % 8;
    bit m;
    bit ae;
    @(negedge clk);
    op = o[7:0]; fz = z; fc = c;
    @(posedge clk);
    #2;
    m  = met_of(o, z, c);
    ae = (g == 2) || (g == 3 && x == 6);
    chk("R1", "reg_dst", int'(reg_dst), y);
    chk("R1", "reg_src", int'(reg_src), x);
    chk("R1", "reg_pair", int'(reg_pair), y / 2);
    chk("R1", "cond_code", int'(cond_code), y % 4);
    chk("R2", "cond_met", int'(cond_met), int'(m));
    chk("R2", "taken", int'(taken), int'(is_cnd(o) && m));
    chk(cyc_tag(o), "cycles", int'(cycles), exp_cyc(o, z, c));
    chk("R4", "rst_addr", int'(rst_addr), (g == 3 && x == 7) ? (o % 64) - x : 0);
    chk("R5", "halt", int'(halt), int'(o == 'h76));
    chk("R6", "alu_en", int'(alu_en), int'(ae));
    chk("R6", "alu_op", int'(alu_op), ae ? y : 0);
    chk("R9", "illegal", int'(illegal), int'(is_bad(o)));
    chk("R10", "cb_prefix", int'(cb_prefix), int'(o == 'hCB));
    chk("R11", "ime_set", int'(ime_set), int'(o == 'hFB || o == 'hD9));
    chk("R11", "ime_clr", int'(ime_clr), int'(o == 'hF3));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    // Idle state after start-up: NOP with flags clear
    @(negedge clk);
    #2;
    chk("R8", "idle cycles", int'(cycles), 4);
    chk("R9", "idle illegal", int'(illegal), 0);
    chk("R2", "idle taken", int'(taken), 0);
    // Full sweep: every opcode under every flag combination
    for (int f = 0; f < 4; f++) begin
      for (int o = 0; o < 256; o++) begin
        apply(o, f[0], f[1]);
      end
    end
    // Boundary spot checks on the condition-dependent costs
    apply('h20, 1'b0, 1'b0); chk("R3", "JR NZ taken", int'(cycles), 12);
    apply('h20, 1'b1, 1'b0); chk("R3", "JR NZ skip", int'(cycles), 8);
    apply('hD8, 1'b0, 1'b1); chk("R3", "RET C taken", int'(cycles), 20);
    apply('hDC, 1'b0, 1'b0); chk("R3", "CALL C skip", int'(cycles), 12);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule